// File: doc/BRIEF.md
# Key-Protected Two-Stage Watchdog Timer

This block is a watchdog that software drives through a single write port carrying an arm bit and a 3-bit key. While it is stopped, a write with the arm bit set starts it and stores the written key. While it runs, only a write whose key is the bitwise inverse of the stored key counts as service. With the arm bit set, such a write restarts the timeout and stores the inverted key. With the arm bit clear, it stops the watchdog. Any other write while running only swaps in the new key. A stray or runaway write is therefore unlikely to keep the watchdog alive.

Time is measured in strobes on a `tick` input that comes from a shared timebase, so both intervals are tick-count parameters. If no service arrives within the first interval, the block raises a level-held NMI request. If service is still missing after a further grace interval, it emits a one-cycle chip reset pulse and returns to the stopped state. A valid restart or stop clears a pending NMI and zeroes both interval counters.

Top module: `keyed_watchdog`

## Requirements
- R1: After a synchronous reset the watchdog is stopped, with `nmi_req` and `chip_rst` both low.
- R2: While stopped, a write with `wr_arm` = 0 has no effect: ticks beyond the first interval raise no NMI request.
- R3: While stopped, a write with `wr_arm` = 1 starts the watchdog and stores `wr_key`. `nmi_req` rises in the cycle after the NMI_TICKS-th tick that follows the start.
- R4: While running, a write with `wr_arm` = 1 and `wr_key` equal to the bitwise inverse of the stored 3-bit key restarts the timeout. It also zeroes the grace counter and stores `wr_key`, so the next service must present the inverse of that new key.
- R5: While running, a write with `wr_arm` = 0 and `wr_key` equal to the inverse of the stored key stops the watchdog and clears `nmi_req`. Later ticks have no effect.
- R6: While running, a write whose key is not the inverse of the stored key only replaces the stored key. Counting continues, and a pending NMI stays raised.
- R7: `nmi_req` stays high until a valid restart or stop, which clears it in the next cycle.
- R8: When GRACE_TICKS ticks pass after `nmi_req` rises without service, `chip_rst` is high for exactly one cycle. In that same cycle `nmi_req` falls and the watchdog returns to stopped.
- R9: A write takes priority over a tick in the same cycle. A valid service coinciding with a tick counts no tick toward the new timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe, one cycle per count |
| wr_en | input | 1 | Control write strobe |
| wr_arm | input | 1 | Arm bit of the written value |
| wr_key | input | 3 | Key field of the written value |
| nmi_req | output | 1 | Level-held non-maskable interrupt request |
| chip_rst | output | 1 | One-cycle chip reset pulse |

## Verification
The hardest state to reach from the ports is the grace stage after a key that has changed several times. Service depends on a key history that the ports never show. The stimulus walks through that history on purpose. It starts with a known key, rekeys with a value that is not the inverse, and then tries the inverse of the old key, which must now fail. Only the inverse of the latest key stops the watchdog. One sequence lets two grace ticks elapse, services, and times out again. This shows that a restart really zeroed the grace count. Another sequence places a restart on the same cycle as the last tick before expiry.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;

    localparam int unsigned KEY_W = 3;

    typedef logic [KEY_W-1:0] wd_key_t;

    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_ARMED = 2'd1,
        WD_ALERT = 2'd2
    } wd_state_e;

    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_START = 3'd1,
        CMD_KICK  = 3'd2,
        CMD_HALT  = 3'd3,
        CMD_REKEY = 3'd4
    } wd_cmd_e;

    typedef struct packed {
        logic    en;
        logic    arm;
        wd_key_t key;
    } wd_write_t;

    // Classify one write against the running state and the held key.
    function automatic wd_cmd_e classify(input wd_write_t wr,
                                         input logic      running,
                                         input wd_key_t   held);
        wd_cmd_e c;
        c = CMD_NONE;
        if (wr.en) begin
            if (!running) begin
                c = wr.arm ? CMD_START : CMD_NONE;
            end else if (wr.key == ~held) begin
                c = wr.arm ? CMD_KICK : CMD_HALT;
            end else begin
                c = CMD_REKEY;
            end
        end
        return c;
    endfunction

    function automatic logic is_service(input wd_cmd_e c);
        return (c == CMD_START) || (c == CMD_KICK) || (c == CMD_HALT);
    endfunction

    function automatic logic loads_key(input wd_cmd_e c);
        return (c == CMD_START) || (c == CMD_KICK) || (c == CMD_REKEY);
    endfunction

endpackage

// File: rtl/wdog_cmd_decode.sv
module wdog_cmd_decode
    import keyed_wdog_pkg::*;
(
    input  wd_write_t wr,
    input  logic      running,
    input  wd_key_t   held_key,
    output wd_cmd_e   cmd
);
    always_comb begin
        cmd = classify(wr, running, held_key);
    end
endmodule

// File: rtl/wdog_key_reg.sv
module wdog_key_reg
    import keyed_wdog_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  wd_key_t din,
    output wd_key_t key_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            key_q <= '0;
        end else if (load) begin
            key_q <= din;
        end
    end
endmodule

// File: rtl/wdog_stage_timer.sv
module wdog_stage_timer #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign expire = run && tick && !clr && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (run && tick) begin
            cnt_q <= expire ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import keyed_wdog_pkg::*;
#(
    parameter int unsigned NMI_TICKS   = 1000,
    parameter int unsigned GRACE_TICKS = 33
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_en,
    input  logic             wr_arm,
    input  logic [KEY_W-1:0] wr_key,
    output logic             nmi_req,
    output logic             chip_rst
);
    localparam int unsigned N_STAGES = 2;

    wd_state_e state_q, state_d;
    wd_key_t   key_q;
    wd_cmd_e   cmd;
    wd_write_t wr;
    logic      svc;
    logic      nmi_q, chip_rst_q;
    logic [N_STAGES-1:0] stage_run, stage_exp;

    assign wr = '{en: wr_en, arm: wr_arm, key: wr_key};

    wdog_cmd_decode u_decode (
        .wr       (wr),
        .running  (state_q != WD_IDLE),
        .held_key (key_q),
        .cmd      (cmd)
    );

    wdog_key_reg u_key (
        .clk   (clk),
        .rst   (rst),
        .load  (loads_key(cmd)),
        .din   (wr_key),
        .key_q (key_q)
    );

    assign svc          = is_service(cmd);
    assign stage_run[0] = (state_q == WD_ARMED);
    assign stage_run[1] = (state_q == WD_ALERT);

    for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
        wdog_stage_timer #(
            .LIMIT((g == 0) ? NMI_TICKS : GRACE_TICKS)
        ) u_timer (
            .clk    (clk),
            .rst    (rst),
            .clr    (svc),
            .run    (stage_run[g]),
            .tick   (tick),
            .expire (stage_exp[g])
        );
    end

    always_comb begin
        state_d = state_q;
        unique case (cmd)
            CMD_START, CMD_KICK: state_d = WD_ARMED;
            CMD_HALT:            state_d = WD_IDLE;
            default: begin
                if (stage_run[0] && stage_exp[0]) begin
                    state_d = WD_ALERT;
                end else if (stage_run[1] && stage_exp[1]) begin
                    state_d = WD_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= WD_IDLE;
            nmi_q      <= 1'b0;
            chip_rst_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            nmi_q      <= (state_d == WD_ALERT);
            chip_rst_q <= stage_run[1] && stage_exp[1];
        end
    end

    assign nmi_req  = nmi_q;
    assign chip_rst = chip_rst_q;

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
    import keyed_wdog_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             wr_arm,
    input logic [KEY_W-1:0] wr_key,
    input logic [KEY_W-1:0] key_q,
    input wd_state_e        state_q,
    input logic             nmi_req,
    input logic             chip_rst
);
    logic active, inv_hit;
    assign active  = (state_q != WD_IDLE);
    assign inv_hit = wr_en && (wr_key == ~key_q);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!nmi_req && !chip_rst && state_q == WD_IDLE));

    assert_idle_noarm_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == WD_IDLE && !(wr_en && wr_arm)) |=> (state_q == WD_IDLE && !nmi_req));

    assert_kick_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (active && inv_hit && wr_arm) |=> (!nmi_req && state_q == WD_ARMED && key_q == $past(wr_key)));

    assert_halt_stops_R5: assert property (@(posedge clk) disable iff (rst)
        (active && inv_hit && !wr_arm) |=> (!nmi_req && state_q == WD_IDLE));

    assert_rekey_only_R6: assert property (@(posedge clk) disable iff (rst)
        (active && wr_en && !inv_hit) |=> ((state_q != WD_IDLE || chip_rst) && key_q == $past(wr_key)));

    assert_nmi_held_R7: assert property (@(posedge clk) disable iff (rst)
        (nmi_req && !inv_hit) |=> (nmi_req || chip_rst));

    assert_rst_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        chip_rst |=> !chip_rst);

    assert_rst_after_nmi_R8: assert property (@(posedge clk) disable iff (rst)
        chip_rst |-> ($past(nmi_req) && !nmi_req && state_q == WD_IDLE));
endmodule

bind keyed_watchdog wdog_checker u_wdog_checker (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_arm   (wr_arm),
    .wr_key   (wr_key),
    .key_q    (key_q),
    .state_q  (state_q),
    .nmi_req  (nmi_req),
    .chip_rst (chip_rst)
);

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
    localparam int unsigned NT = 8;
    localparam int unsigned GT = 3;

    typedef struct {
        logic  nmi;
        logic  rst_pulse;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_arm = 1'b0;
    logic [2:0] wr_key = 3'd0;
    logic       nmi_req, chip_rst;

    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    keyed_watchdog #(.NMI_TICKS(NT), .GRACE_TICKS(GT)) u_keyed_watchdog (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
        .wr_arm(wr_arm), .wr_key(wr_key),
        .nmi_req(nmi_req), .chip_rst(chip_rst)
    );

    // Monitor: compares queued expectations mid-cycle.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            total++;
            if (nmi_req !== e.nmi || chip_rst !== e.rst_pulse) begin
                bad++;
                $display("FAIL %s: nmi=%b rst=%b expected nmi=%b rst=%b",
                         e.tag, nmi_req, chip_rst, e.nmi, e.rst_pulse);
            end
        end
    end

    task automatic expect_out(input logic n, input logic r, input string tag);
        exp_t e;
        e.nmi = n; e.rst_pulse = r; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Applies one cycle of stimulus; returns just after the consuming edge.
    task automatic drive(input logic en, input logic arm, input logic [2:0] key, input logic tk);
        wr_en = en; wr_arm = arm; wr_key = key; tick = tk;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_arm = 1'b0; wr_key = 3'd0; tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 3'd0, 1'b1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 3'd0, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        expect_out(1'b0, 1'b0, "R1 reset state");

        // R2: disarmed write while stopped
        drive(1'b1, 1'b0, 3'd5, 1'b0);
        ticks(NT + 2);
        expect_out(1'b0, 1'b0, "R2 stopped write ignored");

        // R3: start with key 2
        drive(1'b1, 1'b1, 3'd2, 1'b0);
        ticks(NT - 1);
        expect_out(1'b0, 1'b0, "R3 one tick before timeout");
        ticks(1);
        expect_out(1'b1, 1'b0, "R3 nmi at timeout");

        // R7: held, two grace ticks elapse, then restart with ~2 = 5
        idle(3);
        expect_out(1'b1, 1'b0, "R7 nmi held idle");
        ticks(GT - 1);
        expect_out(1'b1, 1'b0, "R7 nmi held in grace");
        drive(1'b1, 1'b1, 3'd5, 1'b0);
        expect_out(1'b0, 1'b0, "R7 restart clears nmi");

        // R4: full timeout again and grace counter zeroed; key is now 5
        ticks(NT - 1);
        expect_out(1'b0, 1'b0, "R4 full timeout restarted");
        ticks(1);
        expect_out(1'b1, 1'b0, "R4 nmi after restarted timeout");
        ticks(GT - 1);
        expect_out(1'b1, 1'b0, "R4 grace count restarted");
        drive(1'b1, 1'b1, 3'd2, 1'b0);
        expect_out(1'b0, 1'b0, "R4 inverse of stored inverted key accepted");

        // R5: key is 2, stop with 5
        ticks(NT);
        expect_out(1'b1, 1'b0, "R5 nmi before stop");
        drive(1'b1, 1'b0, 3'd5, 1'b0);
        expect_out(1'b0, 1'b0, "R5 stop clears nmi");
        ticks(NT + 4);
        expect_out(1'b0, 1'b0, "R5 stays stopped");

        // R6: wrong key only rekeys
        drive(1'b1, 1'b1, 3'd1, 1'b0);
        ticks(5);
        drive(1'b1, 1'b1, 3'd3, 1'b0);
        expect_out(1'b0, 1'b0, "R6 wrong key no effect yet");
        ticks(NT - 5);
        expect_out(1'b1, 1'b0, "R6 counting continued");
        drive(1'b1, 1'b0, 3'd6, 1'b0);
        expect_out(1'b1, 1'b0, "R6 old inverse rejected");
        drive(1'b1, 1'b0, 3'd1, 1'b0);
        expect_out(1'b0, 1'b0, "R6 inverse of latest key stops");

        // R8: full expiry
        drive(1'b1, 1'b1, 3'd7, 1'b0);
        ticks(NT);
        expect_out(1'b1, 1'b0, "R8 nmi raised");
        ticks(GT - 1);
        expect_out(1'b1, 1'b0, "R8 before grace end");
        ticks(1);
        expect_out(1'b0, 1'b1, "R8 reset pulse");
        idle(1);
        expect_out(1'b0, 1'b0, "R8 pulse one cycle");
        ticks(NT + 4);
        expect_out(1'b0, 1'b0, "R8 stopped after reset");

        // R9: restart coinciding with a tick counts no tick
        drive(1'b1, 1'b1, 3'd0, 1'b0);
        ticks(NT - 1);
        drive(1'b1, 1'b1, 3'd7, 1'b1);
        expect_out(1'b0, 1'b0, "R9 restart wins over tick");
        ticks(NT - 1);
        expect_out(1'b0, 1'b0, "R9 coinciding tick not counted");
        ticks(1);
        expect_out(1'b1, 1'b0, "R9 nmi after full timeout");
        drive(1'b1, 1'b0, 3'd0, 1'b1);
        expect_out(1'b0, 1'b0, "R9 stop with tick");

        @(negedge clk); #1;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule